// File: doc/BRIEF.md
# Display Supply Rail Power-Up Sequencer

This block is the digital controller that brings up the four supply rails of a display power unit: the reference and logic rail, the boost converter, the negative gate rail and the positive gate rail. It uses an internal phase timer in place of an external timing capacitor. The timer produces alternating rising and falling phases, each `RAMP_CYC` clock cycles long. A ramp is one rising phase followed by one falling phase. The peak of a ramp is the last cycle of its rising phase. Six ramps make up a full power-up, and every rail enable and every health check is tied to a particular ramp start, peak or end.

The supply-good flag alone brings up the reference and the logic rail. The ramps start only while the enable pin is high. Before soft-start, the reference must be in range and the die must not be over temperature, or the sequence latches into a fault. An external per-check fault flag is sampled at two check points: the end of ramp 2 and the end of ramp 6. A failure at either point also latches the fault. In fault, every output except the reference is off. The fault latch clears only when enable goes low or supply-good drops.

The controller has four states. IDLE waits, RUN counts the ramps, DONE holds the rails up and FAULT holds them down. The transitions are:
- IDLE→RUN on supply-good and enable.
- RUN→DONE at the end of ramp 6 when the check passes.
- RUN→FAULT on a failed check.
- Any state→IDLE when enable or supply-good is low.

Top module: `pwr_seq_top`

## Requirements
- R1: In IDLE, `ref_en` and `logic_en` follow `supply_ok`. `prot_drv`=1 and `dboost_n`=1, while `ss_en`, `neg_en`, `pos_en` and `seq_done` are 0. `prot_drv`=1 means the protection switch is off, and `dboost_n` is active low.
- R2: The sequence starts only when `supply_ok` and `en` are both 1. With `en` low, or with `supply_ok` low, the block stays in IDLE. Offset 0 is the first cycle after the clock edge that samples both inputs high.
- R3: During RUN, `ref_en`=`logic_en`=1. `prot_drv` stays 1 through the peak of ramp 2 (offset 3R-1, where R=`RAMP_CYC`) and is 0 from offset 3R.
- R4: `ss_en` rises at the start of ramp 3 (offset 4R).
- R5: `neg_en` rises just after the peak of ramp 4 (offset 7R).
- R6: `dboost_n` goes low just after the peak of ramp 5 (offset 9R).
- R7: `pos_en` rises at the start of ramp 6 (offset 10R).
- R8: `chk_fail` is sampled at the end of ramp 2 (offset 4R-1) and at the end of ramp 6 (offset 12R-1). A high sample moves the block to FAULT on the next cycle. If every check passes, `seq_done`=1 from offset 12R with all rails on, `prot_drv`=0 and `dboost_n`=0.
- R9: If `ref_ok`=0 or `ot`=1 in any cycle of ramps 1–2 (offsets 0..4R-1), FAULT follows on the next cycle. In FAULT, `ref_en`=`supply_ok`, `prot_drv`=1, `dboost_n`=1 and every other output is 0.
- R10: FAULT holds while `en` and `supply_ok` stay high, even after the faulting input recovers. `en` low or `supply_ok` low returns the block to IDLE.
- R11: `chk_fail` outside the two check points, and `ref_ok`/`ot` from offset 4R on, have no effect.
- R12: From RUN or DONE, `en` low or `supply_ok` low returns the block to IDLE on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Input supply above its undervoltage level |
| en | input | 1 | Enable pin |
| ref_ok | input | 1 | Reference within range |
| ot | input | 1 | Die over temperature |
| chk_fail | input | 1 | Per-check fault flag from the rail monitors |
| ref_en | output | 1 | Reference enable |
| logic_en | output | 1 | Logic rail enable |
| prot_drv | output | 1 | Input-protection switch drive, 1 = switch off |
| ss_en | output | 1 | Boost soft-start enable |
| neg_en | output | 1 | Negative rail enable |
| dboost_n | output | 1 | Delayed-boost switch drive, active low |
| pos_en | output | 1 | Positive rail enable |
| seq_done | output | 1 | Power-up complete |

## Verification
With a small ramp length, the bench checks every output on every cycle of a full sequence against the offsets 3R, 4R, 7R, 9R and 10R. An off-by-one in the peak or ramp-start decode moves an edge by a cycle or by a whole phase. The check flag is pulsed once at each offset of the run. Only the two check points may fault, so a design that sampled it continuously, or at the wrong edge, would fault too often or complete when it should not. Reference and temperature faults are swept across the whole pre-soft-start window and one cycle past it, which exposes a window that ends early or late. Each fault is then held with enable high to confirm that it latches, and cleared both by enable and by supply-good.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam int SEQ_RAMPS = 6;
    localparam int IDX_W     = $clog2(SEQ_RAMPS + 2);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp
    import pwr_seq_pkg::*;
#(
    parameter int RAMP_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [IDX_W-1:0] ramp_idx,
    output logic             rising,
    output logic             last
);
    localparam int CW = (RAMP_CYC > 2) ? $clog2(RAMP_CYC) : 1;

    logic [CW-1:0] cnt;

    assign last = (cnt == CW'(RAMP_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rising   <= 1'b1;
            ramp_idx <= IDX_W'(1);
        end else if (!run) begin
            cnt      <= '0;
            rising   <= 1'b1;
            ramp_idx <= IDX_W'(1);
        end else if (last) begin
            cnt    <= '0;
            rising <= !rising;
            if (!rising)
                ramp_idx <= ramp_idx + IDX_W'(1);
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             en,
    input  logic             ref_ok,
    input  logic             ot,
    input  logic             chk_fail,
    input  logic [IDX_W-1:0] ramp_idx,
    input  logic             rising,
    input  logic             last,
    output seq_state_t       state,
    output logic             timer_run,
    output logic             ref_en,
    output logic             logic_en,
    output logic             prot_drv,
    output logic             ss_en,
    output logic             neg_en,
    output logic             dboost_n,
    output logic             pos_en,
    output logic             seq_done
);
    seq_state_t nxt;
    logic       ramp_end;
    logic       pre_ss;
    logic       chk_pt;
    logic       past_peak2, past_peak4, past_peak5;

    assign ramp_end   = !rising && last;
    assign pre_ss     = (ramp_idx <= IDX_W'(2));
    assign chk_pt     = ramp_end && (ramp_idx == IDX_W'(2) || ramp_idx == IDX_W'(SEQ_RAMPS));
    assign past_peak2 = (ramp_idx > IDX_W'(2)) || (ramp_idx == IDX_W'(2) && !rising);
    assign past_peak4 = (ramp_idx > IDX_W'(4)) || (ramp_idx == IDX_W'(4) && !rising);
    assign past_peak5 = (ramp_idx > IDX_W'(5)) || (ramp_idx == IDX_W'(5) && !rising);
    assign timer_run  = (state == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (supply_ok && en) nxt = ST_RUN;
            ST_RUN: begin
                if (pre_ss && (!ref_ok || ot))
                    nxt = ST_FAULT;
                else if (chk_pt && chk_fail)
                    nxt = ST_FAULT;
                else if (ramp_end && ramp_idx == IDX_W'(SEQ_RAMPS))
                    nxt = ST_DONE;
            end
            ST_DONE:  nxt = ST_DONE;
            ST_FAULT: nxt = ST_FAULT;
        endcase
        if (!supply_ok || !en) nxt = ST_IDLE;
    end

    // outputs
    always_comb begin
        ref_en   = supply_ok;
        logic_en = 1'b0;
        prot_drv = 1'b1;
        ss_en    = 1'b0;
        neg_en   = 1'b0;
        dboost_n = 1'b1;
        pos_en   = 1'b0;
        seq_done = 1'b0;
        unique case (state)
            ST_IDLE: logic_en = supply_ok;
            ST_RUN: begin
                logic_en = 1'b1;
                prot_drv = !past_peak2;
                ss_en    = (ramp_idx >= IDX_W'(3));
                neg_en   = past_peak4;
                dboost_n = !past_peak5;
                pos_en   = (ramp_idx >= IDX_W'(SEQ_RAMPS));
            end
            ST_DONE: begin
                logic_en = 1'b1;
                prot_drv = 1'b0;
                ss_en    = 1'b1;
                neg_en   = 1'b1;
                dboost_n = 1'b0;
                pos_en   = 1'b1;
                seq_done = 1'b1;
            end
            ST_FAULT: ;
        endcase
    end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int RAMP_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic en,
    input  logic ref_ok,
    input  logic ot,
    input  logic chk_fail,
    output logic ref_en,
    output logic logic_en,
    output logic prot_drv,
    output logic ss_en,
    output logic neg_en,
    output logic dboost_n,
    output logic pos_en,
    output logic seq_done
);
    seq_state_t       seq_state;
    logic             timer_run;
    logic [IDX_W-1:0] ramp_idx;
    logic             rising;
    logic             last;

    pwr_seq_ramp #(.RAMP_CYC(RAMP_CYC)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (timer_run),
        .ramp_idx (ramp_idx),
        .rising   (rising),
        .last     (last)
    );

    pwr_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .en        (en),
        .ref_ok    (ref_ok),
        .ot        (ot),
        .chk_fail  (chk_fail),
        .ramp_idx  (ramp_idx),
        .rising    (rising),
        .last      (last),
        .state     (seq_state),
        .timer_run (timer_run),
        .ref_en    (ref_en),
        .logic_en  (logic_en),
        .prot_drv  (prot_drv),
        .ss_en     (ss_en),
        .neg_en    (neg_en),
        .dboost_n  (dboost_n),
        .pos_en    (pos_en),
        .seq_done  (seq_done)
    );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       en,
    input logic       logic_en,
    input logic       prot_drv,
    input logic       ss_en,
    input logic       neg_en,
    input logic       dboost_n,
    input logic       pos_en,
    input logic       seq_done,
    input seq_state_t seq_state
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state == ST_IDLE |-> (!ss_en && !neg_en && !pos_en && prot_drv && dboost_n));

    p_start_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && !en) |=> seq_state == ST_IDLE);

    p_ss_after_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ss_en |-> !prot_drv);

    p_neg_after_ss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        neg_en |-> ss_en);

    p_dboost_after_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dboost_n |-> neg_en);

    p_pos_after_dboost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_en |-> !dboost_n);

    p_done_all_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (pos_en && neg_en && ss_en && logic_en && !prot_drv));

    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_FAULT && en && supply_ok) |=> seq_state == ST_FAULT);

    p_supply_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> seq_state == ST_IDLE);
endmodule

bind pwr_seq_top pwr_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .en        (en),
    .logic_en  (logic_en),
    .prot_drv  (prot_drv),
    .ss_en     (ss_en),
    .neg_en    (neg_en),
    .dboost_n  (dboost_n),
    .pos_en    (pos_en),
    .seq_done  (seq_done),
    .seq_state (seq_state)
);

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
    localparam int R = 4;
    localparam int N = 12 * R;

    logic clk = 1'b0;
    logic rst_n, supply_ok, en, ref_ok, ot, chk_fail;
    logic ref_en, logic_en, prot_drv, ss_en, neg_en, dboost_n, pos_en, seq_done;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_top #(.RAMP_CYC(R)) i_pwr_seq_top (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en(en),
        .ref_ok(ref_ok), .ot(ot), .chk_fail(chk_fail),
        .ref_en(ref_en), .logic_en(logic_en), .prot_drv(prot_drv),
        .ss_en(ss_en), .neg_en(neg_en), .dboost_n(dboost_n),
        .pos_en(pos_en), .seq_done(seq_done)
    );

    // vector order: ref, logic, prot, ss, neg, dboost_n, pos, done
    function automatic logic [7:0] f_idle(input logic s);
        return {s, s, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    endfunction

    function automatic logic [7:0] f_fault();
        return 8'b1010_0100;
    endfunction

    function automatic logic [7:0] f_run(input int o);
        if (o >= N) return 8'b1101_1011;
        return {1'b1, 1'b1, logic'(o < 3*R), logic'(o >= 4*R), logic'(o >= 7*R),
                logic'(o < 9*R), logic'(o >= 10*R), 1'b0};
    endfunction

    function automatic string f_tag(input int o);
        if (o >= N)      return "R8";
        if (o >= 10*R)   return "R7";
        if (o >= 9*R)    return "R6";
        if (o >= 7*R)    return "R5";
        if (o >= 4*R)    return "R4";
        return "R3";
    endfunction

    task automatic chk(input logic [7:0] exp, input string tag, input int o);
        logic [7:0] got;
        got = {ref_en, logic_en, prot_drv, ss_en, neg_en, dboost_n, pos_en, seq_done};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s offset %0d: got %b expected %b", tag, o, got, exp);
        end
    endtask

    // kind: 0 none, 1 ref_ok low, 2 ot high, 3 chk_fail pulse, 4 supply drop, 5 en drop
    task automatic do_case(input int kind, input int at);
        bit    faulted = 1'b0;
        bit    gone    = 1'b0;
        string itag    = "";
        en = 1'b1;
        for (int o = 0; o < N + 4; o++) begin
            @(negedge clk);
            if (gone)         chk(f_idle(supply_ok), itag, o);
            else if (faulted) chk(f_fault(), (o == at + 1) ? itag : "R10", o);
            else              chk(f_run(o), (kind != 0 && o > at) ? itag : f_tag(o), o);
            ref_ok = 1'b1; ot = 1'b0; chk_fail = 1'b0;
            if (o == at && !gone && !faulted) begin
                unique case (kind)
                    1: begin ref_ok = 1'b0; faulted = (at < 4*R); itag = faulted ? "R9" : "R11"; end
                    2: begin ot = 1'b1;     faulted = (at < 4*R); itag = faulted ? "R9" : "R11"; end
                    3: begin
                        chk_fail = 1'b1;
                        faulted  = (at == 4*R - 1) || (at == N - 1);
                        itag     = faulted ? "R8" : "R11";
                    end
                    4: begin supply_ok = 1'b0; gone = 1'b1; itag = "R12"; end
                    5: begin en = 1'b0;        gone = 1'b1; itag = "R12"; end
                    default: ;
                endcase
            end
        end
        if (faulted && kind == 2) begin
            supply_ok = 1'b0;
            @(negedge clk);
            chk(f_idle(1'b0), "R10", -1);
            supply_ok = 1'b1;
        end
        en = 1'b0; supply_ok = 1'b1;
        @(negedge clk);
        chk(f_idle(1'b1), faulted ? "R10" : "R12", -1);
    endtask

    initial begin
        rst_n = 1'b0; supply_ok = 1'b0; en = 1'b0; ref_ok = 1'b0; ot = 1'b0; chk_fail = 1'b0;
        repeat (3) @(negedge clk);
        chk(f_idle(1'b0), "R1", -1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(f_idle(1'b0), "R1", -1);
        supply_ok = 1'b1; ref_ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(f_idle(1'b1), "R2", -1);
        end
        do_case(0, -1);
        for (int a = 0; a < N; a++)     do_case(3, a);
        for (int a = 0; a < N; a++)     do_case(1, a);
        for (int a = 0; a <= 4*R; a++)  do_case(2, a);
        do_case(4, 0); do_case(4, 3*R); do_case(4, N - 1); do_case(4, N + 1);
        do_case(5, 0); do_case(5, 3*R); do_case(5, N - 1); do_case(5, N + 1);
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule